// File: doc/BRIEF.md
# Address Region Attribute Matcher

This block sits beside a processor's local bus and assigns memory attributes to each access by comparing the access address against a small bank of programmable region registers. Each register holds an 8-bit base, an 8-bit per-bit ignore mask, an enable, a privilege qualifier, and three attribute bits. These bits make the access uncached, let writes complete before the downstream bus finishes, or forbid writes. The first enabled register that matches the top address byte supplies the attributes. An access that matches none of them gets fixed defaults.

The same decision also controls how a local-bus access is terminated. Reads end in the cycle they are presented. A buffered write ends at once and hands a one-cycle request to the bus controller. An unbuffered write holds its request, and the local bus stays stalled until the system bus acknowledges. A write into a protected region is stopped with a one-cycle error and produces no downstream request.

The requester holds an access (valid, address, direction, mode) stable until it sees `acc_done`. Register writes take effect on the next clock edge. Register reads are combinational.

Top module: `attr_region_matcher`

## Requirements
- R1: After reset every region register reads back as zero, and every access receives the default attributes.
- R2: A register write stores only bits 31..13, 6, 5 and 2 (keep mask 0xFFFFE064). Every other bit reads back as zero.
- R3: A register matches when address bits 31..24 equal its base field (bits 31..24) in every position where its mask field (bits 23..16) holds 0. Positions whose mask bit is 1 are ignored.
- R4: A register whose enable bit (bit 15) is 0 never matches, whatever its other fields hold.
- R5: The privilege field (bits 14..13) matches as follows: 00 matches only user accesses (`acc_super`=0), 01 only supervisor accesses, and 1x both.
- R6: `acc_cacheable` is the inverse of the cache-inhibit bit (bit 6) of the selecting register.
- R7: When several registers match, the lowest-numbered one supplies all attributes.
- R8: An access matching no register is cacheable, unbuffered and not write-protected.
- R9: A write to a region whose write-protect bit (bit 2) is 1 asserts `acc_err` and `acc_done` in the same cycle, with `sys_req` low. A read of such a region completes normally with no error.
- R10: An unbuffered write (bit 5 = 0) raises `sys_req` and holds it. `acc_done` rises only in the cycle `sys_ack` is high.
- R11: A buffered write (bit 5 = 1) asserts `acc_done` and `sys_req` in the cycle it is presented, whatever `sys_ack` is. `acc_buffered` reports bit 5 of the selecting register.
- R12: A read asserts `acc_done` in the cycle it is presented and never raises `sys_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_waddr | input | IDX_W | Region register index for writes |
| cfg_wdata | input | 32 | Region register write data |
| cfg_raddr | input | IDX_W | Region register index for reads |
| cfg_rdata | output | 32 | Region register read data (combinational) |
| acc_valid | input | 1 | Local-bus access present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_super | input | 1 | 1 = supervisor access, 0 = user |
| sys_ack | input | 1 | System bus acknowledges the pending write |
| acc_cacheable | output | 1 | Resolved cacheable attribute |
| acc_buffered | output | 1 | Resolved buffered-write attribute |
| acc_err | output | 1 | Write-protect access error |
| acc_done | output | 1 | Local-bus termination |
| sys_req | output | 1 | Write request toward the bus controller |

## Verification
The hardest case to reach is an access that several enabled registers match at once, where the registers disagree on every attribute and the privilege qualifier decides whether the lower-numbered register takes part. It is hardest when that access is also an unbuffered write stalled on the system bus. The bench programs two overlapping regions with conflicting attributes and steps the privilege code of the lower region through all four values. It also runs a configuration where both regions are fully populated but disabled. For each configuration it sweeps every top address byte in both modes and both directions, and completes each stalled write with a late acknowledge. A separate run holds an unbuffered write for several cycles before the acknowledge arrives.

// File: rtl/arm_pkg.sv
package arm_pkg;
   localparam int CFG_W = 32;
   localparam logic [CFG_W-1:0] CFG_KEEP = 32'hFFFF_E064;
   localparam int BASE_LSB = 24;
   localparam int MASK_LSB = 16;
   localparam int EN_BIT   = 15;
   localparam int PRIV_LSB = 13;
   localparam int CI_BIT   = 6;
   localparam int BW_BIT   = 5;
   localparam int WP_BIT   = 2;

   typedef struct packed {
      logic cinh;
      logic bufw;
      logic wprot;
   } attr_t;
endpackage

// File: rtl/arm_region_entry.sv
module arm_region_entry
   import arm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   input  logic [7:0]       addr_hi,
   input  logic             super_mode,
   output logic [CFG_W-1:0] cfg_q,
   output logic             hit,
   output attr_t            attr
);
   logic [7:0] base_f, mask_f;
   logic [1:0] priv_f;
   logic       priv_ok, addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (we) cfg_q <= wdata & CFG_KEEP;
   end

   assign base_f  = cfg_q[BASE_LSB +: 8];
   assign mask_f  = cfg_q[MASK_LSB +: 8];
   assign priv_f  = cfg_q[PRIV_LSB +: 2];
   assign priv_ok = priv_f[1] | (priv_f[0] == super_mode);
   assign addr_ok = ((addr_hi ^ base_f) & ~mask_f) == 8'h00;
   assign hit     = cfg_q[EN_BIT] & priv_ok & addr_ok;

   assign attr.cinh  = cfg_q[CI_BIT];
   assign attr.bufw  = cfg_q[BW_BIT];
   assign attr.wprot = cfg_q[WP_BIT];
endmodule

// File: rtl/arm_prio_sel.sv
module arm_prio_sel
   import arm_pkg::*;
#(
   parameter int NUM_REGIONS     = 2,
   parameter bit DFLT_CACHEABLE  = 1'b1
) (
   input  logic [NUM_REGIONS-1:0] hit,
   input  attr_t [NUM_REGIONS-1:0] attrs,
   output attr_t                  sel
);
   localparam attr_t DFLT = '{cinh: ~DFLT_CACHEABLE, bufw: 1'b0, wprot: 1'b0};

   if (NUM_REGIONS == 1) begin : g_single
      assign sel = hit[0] ? attrs[0] : DFLT;
   end else begin : g_multi
      always_comb begin
         sel = DFLT;
         for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) sel = attrs[i];
         end
      end
   end
endmodule

// File: rtl/arm_term_ctrl.sv
module arm_term_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic write,
   input  logic bufw,
   input  logic wprot,
   input  logic sys_ack,
   output logic done,
   output logic err,
   output logic sys_req
);
   logic wait_q, wait_d;

   always_comb begin
      done    = 1'b0;
      err     = 1'b0;
      sys_req = 1'b0;
      wait_d  = wait_q;
      if (wait_q) begin
         sys_req = 1'b1;
         done    = sys_ack;
         if (sys_ack) wait_d = 1'b0;
      end else if (valid) begin
         if (!write) begin
            done = 1'b1;
         end else if (wprot) begin
            done = 1'b1;
            err  = 1'b1;
         end else if (bufw) begin
            done    = 1'b1;
            sys_req = 1'b1;
         end else begin
            sys_req = 1'b1;
            done    = sys_ack;
            if (!sys_ack) wait_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= 1'b0;
      else        wait_q <= wait_d;
   end
endmodule

// File: rtl/attr_region_matcher.sv
module attr_region_matcher
   import arm_pkg::*;
#(
   parameter int NUM_REGIONS    = 2,
   parameter int ADDR_W         = 32,
   parameter bit DFLT_CACHEABLE = 1'b1,
   localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_waddr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [IDX_W-1:0]  cfg_raddr,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_super,
   input  logic              sys_ack,
   output logic              acc_cacheable,
   output logic              acc_buffered,
   output logic              acc_err,
   output logic              acc_done,
   output logic              sys_req
);
   if (NUM_REGIONS < 1 || NUM_REGIONS > 16) begin : g_bad_regions
      $error("NUM_REGIONS must lie in 1..16");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must be at least 9");
   end

   logic [7:0]             addr_hi;
   logic                   unused_lo;
   logic [NUM_REGIONS-1:0] hit;
   attr_t [NUM_REGIONS-1:0] attrs;
   logic [CFG_W-1:0]       cfg_q [NUM_REGIONS];
   attr_t                  sel;

   assign addr_hi   = acc_addr[ADDR_W-1 -: 8];
   assign unused_lo = ^acc_addr[ADDR_W-9:0];

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
      arm_region_entry u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .we         (cfg_we && (int'(cfg_waddr) == g)),
         .wdata      (cfg_wdata),
         .addr_hi    (addr_hi),
         .super_mode (acc_super),
         .cfg_q      (cfg_q[g]),
         .hit        (hit[g]),
         .attr       (attrs[g])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (int'(cfg_raddr) == i) cfg_rdata = cfg_q[i];
      end
   end

   arm_prio_sel #(
      .NUM_REGIONS    (NUM_REGIONS),
      .DFLT_CACHEABLE (DFLT_CACHEABLE)
   ) u_sel (
      .hit   (hit),
      .attrs (attrs),
      .sel   (sel)
   );

   assign acc_cacheable = ~sel.cinh;
   assign acc_buffered  = sel.bufw;

   arm_term_ctrl u_term (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (acc_valid),
      .write   (acc_write),
      .bufw    (sel.bufw),
      .wprot   (sel.wprot),
      .sys_ack (sys_ack),
      .done    (acc_done),
      .err     (acc_err),
      .sys_req (sys_req)
   );
endmodule

// File: rtl/attr_region_matcher_chk.sv
module attr_region_matcher_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cfg_rdata,
   input logic        acc_valid,
   input logic        acc_write,
   input logic        acc_buffered,
   input logic        acc_err,
   input logic        acc_done,
   input logic        sys_req,
   input logic        sys_ack
);
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~32'hFFFF_E064) == 32'h0);

   p_err_write_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> (acc_valid && acc_write && acc_done && !sys_req));

   p_done_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !acc_buffered && !acc_err && sys_req) |-> (acc_done == sys_ack));

   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_req && !acc_done && !acc_buffered) |=> sys_req);

   p_buf_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_buffered && !acc_err) |-> (acc_done && sys_req));

   p_read_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |-> (acc_done && !sys_req && !acc_err));
endmodule

bind attr_region_matcher attr_region_matcher_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_rdata    (cfg_rdata),
   .acc_valid    (acc_valid),
   .acc_write    (acc_write),
   .acc_buffered (acc_buffered),
   .acc_err      (acc_err),
   .acc_done     (acc_done),
   .sys_req      (sys_req),
   .sys_ack      (sys_ack)
);

// File: tb/attr_region_matcher_tb.sv
module attr_region_matcher_tb;
   localparam int N = 2;
   localparam logic [31:0] KEEP = 32'hFFFF_E064;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [0:0]  cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [0:0]  cfg_raddr = '0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_super = 1'b0;
   logic        sys_ack = 1'b0;
   logic        acc_cacheable, acc_buffered, acc_err, acc_done, sys_req;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [31:0] exp_reg [N];

   always #2 clk = ~clk;

   attr_region_matcher u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_super(acc_super), .sys_ack(sys_ack), .acc_cacheable(acc_cacheable),
      .acc_buffered(acc_buffered), .acc_err(acc_err), .acc_done(acc_done),
      .sys_req(sys_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [7:0] base, input logic [7:0] mask, input bit en,
                                      input logic [1:0] priv, input bit ci, input bit bw, input bit wp);
      mk = {base, mask, en, priv, 6'b0, ci, bw, 2'b0, wp, 2'b0};
   endfunction

   // returns {cache_inhibit, buffered, write_protect}; R3 R4 R5 R7 R8
   function automatic logic [2:0] model(input logic [7:0] a, input bit sup);
      model = 3'b000;
      for (int i = N - 1; i >= 0; i--) begin
         logic [31:0] r;
         bit pm, am;
         r  = exp_reg[i];
         pm = r[14] | (r[13] == sup);
         am = ((a ^ r[31:24]) & ~r[23:16]) == 8'h00;
         if (r[15] && pm && am) model = {r[6], r[5], r[2]};
      end
   endfunction

   task automatic cfg_write(input int idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = idx[0:0]; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      exp_reg[idx] = d & KEEP;
      cfg_raddr = idx[0:0];
      #1;
      chk(cfg_rdata == (d & KEEP), "R2 readback", cfg_rdata, d & KEEP);
   endtask

   task automatic access(input logic [7:0] a, input bit sup, input bit wr);
      logic [2:0] m;
      bit e_err, e_req, e_done;
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = {a, 24'h5A_C3_96}; acc_super = sup; acc_write = wr; sys_ack = 1'b0;
      #1;
      m = model(a, sup);
      e_err  = wr & m[0];
      e_req  = wr & ~m[0];
      e_done = ~wr | m[0] | m[1];
      chk(acc_cacheable == ~m[2], "R6 cacheable", {31'b0, acc_cacheable}, {31'b0, ~m[2]});
      chk(acc_buffered == m[1], "R11 buffered", {31'b0, acc_buffered}, {31'b0, m[1]});
      chk(acc_err == e_err, "R9 err", {31'b0, acc_err}, {31'b0, e_err});
      chk(sys_req == e_req, "R12 sys_req", {31'b0, sys_req}, {31'b0, e_req});
      chk(acc_done == e_done, "R10 done", {31'b0, acc_done}, {31'b0, e_done});
      if (wr && !m[0] && !m[1]) begin
         @(negedge clk);
         sys_ack = 1'b1;
         #1;
         chk(acc_done && sys_req, "R10 done on ack", {30'b0, acc_done, sys_req}, 32'h3);
      end
      @(negedge clk);
      acc_valid = 1'b0; sys_ack = 1'b0; acc_write = 1'b0;
   endtask

   task automatic sweep();
      for (int a = 0; a < 256; a++)
         for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
               access(a[7:0], s[0], w[0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) exp_reg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         cfg_raddr = i[0:0];
         #1;
         chk(cfg_rdata == 32'h0, "R1 reset rdata", cfg_rdata, 32'h0);
      end
      access(8'h40, 1'b0, 1'b0);
      access(8'hC7, 1'b1, 1'b1);

      // R2: all bits set, reserved must read zero
      cfg_write(0, 32'hFFFF_FFFF);
      cfg_write(1, 32'h0000_1F9B);

      // R4: populated but disabled regions never match
      cfg_write(0, mk(8'h40, 8'hFF, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1) | 32'h0000_1F9B);
      cfg_write(1, mk(8'h00, 8'hFF, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1));
      sweep();

      // R3 R5 R7 R8 R9 R11 R12: overlapping regions with conflicting attributes
      for (int p = 0; p < 4; p++) begin
         cfg_write(0, mk(8'h40, 8'h0F, 1'b1, p[1:0], 1'b1, 1'b1, 1'b0) | 32'h0000_1F9B);
         cfg_write(1, mk(8'h4C, 8'h83, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1));
         sweep();
      end

      // R10: long stall on unbuffered write
      cfg_write(0, mk(8'h00, 8'hFF, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0));
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h1234_5678; sys_ack = 1'b0;
      for (int k = 0; k < 5; k++) begin
         #1;
         chk(!acc_done && sys_req, "R10 stall", {30'b0, acc_done, sys_req}, 32'h1);
         @(negedge clk);
      end
      sys_ack = 1'b1;
      #1;
      chk(acc_done && sys_req, "R10 release", {30'b0, acc_done, sys_req}, 32'h3);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; sys_ack = 1'b0;
      #1;
      chk(!sys_req && !acc_done, "R10 idle after ack", {30'b0, acc_done, sys_req}, 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule